// File: doc/BRIEF.md
# Accumulator Bidirectional Shifter

This block shifts one of two 40-bit accumulators, either logically or arithmetically. The shift amount comes either from an 8-bit signed immediate or from a 16-bit signed register operand. The sign of the amount sets the direction. The two amount sources read that sign in opposite ways: a positive immediate moves bits toward the most significant end, and a positive register amount moves them toward the least significant end. A magnitude of 40 or more empties the accumulator, except that an arithmetic right shift fills it with copies of the sign bit.

The caller presents both current accumulator values, a selector, the mode bits and the amount, with a valid strobe. One clock later the block returns the shifted 40-bit value, the selector of the accumulator that must receive it, and four condition flags. Carry and overflow are always cleared. Zero and negative describe the result. Decoding the operation and fetching the register amount from the register file are handled outside the block.

Top module: `acsh_unit`

## Requirements
- R1: In logical mode (`arith_i`=0), the operand is the accumulator's 40 bits taken as an unsigned value, and right shifts bring in zeros at bit 39.
- R2: In arithmetic mode (`arith_i`=1), right shifts copy bit 39 into every vacated position. Left shifts in either mode bring in zeros at bit 0.
- R3: With `use_reg_i`=0, only `amt_i[7:0]` is used, read as two's complement. A value of 0..127 shifts left by that value. A value of -1..-128 shifts right by its magnitude. `amt_i[15:8]` is ignored.
- R4: With `use_reg_i`=1, `amt_i[15:0]` is read as two's complement. A positive value shifts right by that value. Zero leaves the operand unchanged. A negative value shifts left by its magnitude.
- R5: Every result has carry (`flags_o[3]`) and overflow (`flags_o[2]`) equal to 0.
- R6: `sel_b_i`=0 takes the operand from `acc_a_i` and `sel_b_i`=1 takes it from `acc_b_i`. `dst_b_o` repeats that selector, so the result returns to the accumulator it came from.
- R7: A shift magnitude of 40 or more gives all zeros. The exception is an arithmetic right shift, which gives 40 copies of the operand's bit 39.
- R8: `flags_o[1]` (zero) is 1 exactly when the 40-bit result is 0. `flags_o[0]` (negative) equals result bit 39.
- R9: `valid_o`, `res_o`, `dst_b_o` and `flags_o` update on the clock edge that samples `valid_i`=1, so there is one cycle of latency. A synchronous active-low reset clears all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| sel_b_i | input | 1 | Accumulator select (0 = A, 1 = B) |
| arith_i | input | 1 | 1 = arithmetic, 0 = logical |
| use_reg_i | input | 1 | 1 = register amount, 0 = immediate amount |
| amt_i | input | 16 | Shift amount (immediate uses bits 7:0) |
| acc_a_i | input | 40 | Current value of accumulator A |
| acc_b_i | input | 40 | Current value of accumulator B |
| valid_o | output | 1 | Result strobe |
| dst_b_o | output | 1 | Accumulator that receives the result |
| res_o | output | 40 | Shifted value |
| flags_o | output | 4 | {carry, overflow, zero, negative} |

## Verification
Each amount source is driven with small positive and negative values, so an inverted direction convention between the two sources is exposed. The same negative operand is shifted right in both modes, which separates sign filling from zero filling. Magnitudes just below and just above 40 test the saturation threshold: 39, 40, 100, -128 and -32768. An immediate with junk in its upper byte checks that those bits are ignored. Back-to-back requests that alternate between the accumulators, with distinct values in each, show that the operand and its destination stay paired.

// File: rtl/acsh_pkg.sv
// Shared widths and the flag record for the accumulator shifter.
// Assumes a 40-bit accumulator and a 16-bit register amount.
package acsh_pkg;
    parameter int ACC_W = 40;
    parameter int AMT_W = 16;
    parameter int IMM_W = 8;
    localparam int MAG_W = AMT_W + 1;
    localparam int SH_W  = $clog2(ACC_W);

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic neg;
    } acsh_flags_t;
endpackage

// File: rtl/acsh_amt_dec.sv
// Turns the raw amount into a direction and an unsigned magnitude.
// The immediate form (low IMM_W bits) shifts left when non-negative.
// The register form (all AMT_W bits) shifts right when positive.
// Assumes MAG_W > AMT_W, so that the most negative register value fits.
module acsh_amt_dec #(
    parameter int AMT_W = 16,
    parameter int IMM_W = 8,
    parameter int MAG_W = AMT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_reg_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic             left_o,
    output logic [MAG_W-1:0] mag_o
);
    logic [IMM_W:0]   imm_sx;
    logic [IMM_W:0]   imm_neg;
    logic [AMT_W:0]   reg_sx;
    logic [AMT_W:0]   reg_neg;
    logic             reg_pos;

    // Sign-extend each source by one bit and form its negation.
    always_comb begin
        imm_sx  = {amt_i[IMM_W-1], amt_i[IMM_W-1:0]};
        imm_neg = ~imm_sx + 1'b1;
        reg_sx  = {amt_i[AMT_W-1], amt_i};
        reg_neg = ~reg_sx + 1'b1;
        reg_pos = !amt_i[AMT_W-1] && (amt_i != '0);
    end

    // Choose the direction and magnitude under each source's convention.
    always_comb begin
        if (!use_reg_i) begin
            left_o = !amt_i[IMM_W-1];
            mag_o  = left_o ? MAG_W'(imm_sx) : MAG_W'(imm_neg);
        end else begin
            left_o = !reg_pos;
            mag_o  = reg_pos ? MAG_W'(reg_sx) : MAG_W'(reg_neg);
        end
    end

    // R3: a non-negative immediate must shift left.
    p_imm_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_reg_i && !amt_i[IMM_W-1]) |-> left_o);
    // R4: a positive register amount must shift right by exactly that amount.
    p_reg_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (use_reg_i && !amt_i[AMT_W-1] && amt_i != '0) |-> (!left_o && mag_o == MAG_W'(amt_i)));
endmodule

// File: rtl/acsh_barrel.sv
// Log-depth barrel shifter over W bits in either direction.
// Right shifts fill with fill_i. Magnitudes of W or more saturate.
// Assumes the magnitude is unsigned and at least $clog2(W) bits wide.
module acsh_barrel #(
    parameter int W     = 40,
    parameter int MAG_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opnd_i,
    input  logic             left_i,
    input  logic             fill_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [W-1:0]     res_o
);
    localparam int STAGES = $clog2(W);

    logic [W-1:0] stg [0:STAGES];
    logic         sat;

    // Stage zero is the unshifted operand.
    always_comb stg[0] = opnd_i;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            localparam int S = 1 << k;
            // Move by 2^k when magnitude bit k is set.
            always_comb begin
                if (!mag_i[k])
                    stg[k+1] = stg[k];
                else if (left_i)
                    stg[k+1] = {stg[k][W-1-S:0], {S{1'b0}}};
                else
                    stg[k+1] = {{S{fill_i}}, stg[k][W-1:S]};
            end
        end
    endgenerate

    // Replace the stage output when the magnitude reaches the width.
    always_comb begin
        sat = (mag_i >= MAG_W'(W));
        if (sat)
            res_o = left_i ? '0 : {W{fill_i}};
        else
            res_o = stg[STAGES];
    end

    // R2: a left shift by a non-zero amount always leaves bit 0 clear.
    p_left_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (left_i && mag_i != '0) |-> !res_o[0]);
    // R1: a zero-filled right shift by a non-zero amount clears bit W-1.
    p_right_logic_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!left_i && !fill_i && mag_i != '0) |-> !res_o[W-1]);
    // R7: a saturating right shift with sign fill is all ones.
    p_sat_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!left_i && fill_i && mag_i >= MAG_W'(W)) |-> (res_o == {W{1'b1}}));
endmodule

// File: rtl/acsh_flags.sv
// Derives the condition flags of a shift result.
// Carry and overflow are always cleared. Negative is the top bit.
module acsh_flags
    import acsh_pkg::*;
#(
    parameter int W = 40
) (
    input  logic [W-1:0] res_i,
    output acsh_flags_t  flags_o
);
    // Form the four flags from the result alone.
    always_comb begin
        flags_o.carry = 1'b0;
        flags_o.ovf   = 1'b0;
        flags_o.zero  = (res_i == '0);
        flags_o.neg   = res_i[W-1];
    end
endmodule

// File: rtl/acsh_unit.sv
// Top level of the accumulator shifter. Picks the operand from one of two
// accumulators, decodes the amount, shifts and registers the result, its
// destination selector and its flags. Latency is one cycle.
// Assumes the caller writes res_o to the accumulator named by dst_b_o.
module acsh_unit
    import acsh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             sel_b_i,
    input  logic             arith_i,
    input  logic             use_reg_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [ACC_W-1:0] acc_a_i,
    input  logic [ACC_W-1:0] acc_b_i,
    output logic             valid_o,
    output logic             dst_b_o,
    output logic [ACC_W-1:0] res_o,
    output logic [3:0]       flags_o
);
    logic [ACC_W-1:0] opnd;
    logic             left;
    logic [MAG_W-1:0] mag;
    logic             fill;
    logic [ACC_W-1:0] shifted;
    acsh_flags_t      nxt_flags;

    // Pick the source accumulator and the right-shift fill bit.
    always_comb begin
        opnd = sel_b_i ? acc_b_i : acc_a_i;
        fill = arith_i & opnd[ACC_W-1];
    end

    acsh_amt_dec #(
        .AMT_W (AMT_W),
        .IMM_W (IMM_W),
        .MAG_W (MAG_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_reg_i (use_reg_i),
        .amt_i     (amt_i),
        .left_o    (left),
        .mag_o     (mag)
    );

    acsh_barrel #(
        .W     (ACC_W),
        .MAG_W (MAG_W)
    ) u_bar (
        .clk    (clk),
        .rst_n  (rst_n),
        .opnd_i (opnd),
        .left_i (left),
        .fill_i (fill),
        .mag_i  (mag),
        .res_o  (shifted)
    );

    acsh_flags #(
        .W (ACC_W)
    ) u_flg (
        .res_i   (shifted),
        .flags_o (nxt_flags)
    );

    // Register the result, its destination and its flags on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            dst_b_o <= 1'b0;
            res_o   <= '0;
            flags_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                dst_b_o <= sel_b_i;
                res_o   <= shifted;
                flags_o <= nxt_flags;
            end
        end
    end

    // R9: each request produces a result on the next cycle.
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    // R5: carry and overflow are never set on a result.
    p_cv_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (flags_o[3:2] == 2'b00));
    // R6: the destination follows the selector that supplied the operand.
    p_dst_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (dst_b_o == $past(sel_b_i)));
    // R8: the negative flag matches the result's top bit.
    p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (flags_o[0] == res_o[ACC_W-1]));
    // R4: a zero register amount returns the operand unchanged.
    p_zero_amt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && use_reg_i && amt_i == '0) |=> (res_o == $past(opnd)));
endmodule

// File: tb/acsh_unit_bench.sv
module acsh_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        sel_b_i = 1'b0;
    logic        arith_i = 1'b0;
    logic        use_reg_i = 1'b0;
    logic [15:0] amt_i = '0;
    logic [39:0] acc_a_i = '0;
    logic [39:0] acc_b_i = '0;
    logic        valid_o;
    logic        dst_b_o;
    logic [39:0] res_o;
    logic [3:0]  flags_o;

    typedef struct {
        logic [39:0] res;
        logic [3:0]  flg;
        logic        dst;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   drv_done = 1'b0;

    acsh_unit u_acsh_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .sel_b_i   (sel_b_i),
        .arith_i   (arith_i),
        .use_reg_i (use_reg_i),
        .amt_i     (amt_i),
        .acc_a_i   (acc_a_i),
        .acc_b_i   (acc_b_i),
        .valid_o   (valid_o),
        .dst_b_o   (dst_b_o),
        .res_o     (res_o),
        .flags_o   (flags_o)
    );

    always #4 clk = ~clk;

    function automatic logic [39:0] ref_shift(logic ar, logic ur, logic [15:0] a, logic [39:0] x);
        int  v;
        int  m;
        bit  lft;
        logic signed [39:0] sx;
        if (!ur) begin
            v = $signed(a[7:0]);
            lft = (v >= 0);
            m = lft ? v : -v;
        end else begin
            v = $signed(a);
            lft = (v <= 0);
            m = lft ? -v : v;
        end
        sx = x;
        if (lft) return (m >= 40) ? 40'd0 : (x << m);
        if (ar)  return (m >= 40) ? {40{x[39]}} : 40'(sx >>> m);
        return (m >= 40) ? 40'd0 : (x >> m);
    endfunction

    task automatic issue(string tag, logic sb, logic ar, logic ur, logic [15:0] a,
                         logic [39:0] va, logic [39:0] vb);
        exp_t e;
        logic [39:0] r;
        @(negedge clk);
        valid_i = 1'b1; sel_b_i = sb; arith_i = ar; use_reg_i = ur;
        amt_i = a; acc_a_i = va; acc_b_i = vb;
        r = ref_shift(ar, ur, a, sb ? vb : va);
        e.res = r;
        e.flg = {2'b00, (r == 40'd0), r[39]};
        e.dst = sb;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(posedge clk) begin
        #1;
        if (rst_n && valid_o) begin
            exp_t e;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected result R9: got res=%h, expected none", res_o);
            end else begin
                e = exp_q.pop_front();
                if (res_o !== e.res || flags_o !== e.flg || dst_b_o !== e.dst) begin
                    n_bad++;
                    $display("FAIL %s: res=%h flags=%b dst=%b, expected res=%h flags=%b dst=%b",
                             e.tag, res_o, flags_o, dst_b_o, e.res, e.flg, e.dst);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (valid_o !== 1'b0 || res_o !== 40'd0 || flags_o !== 4'd0 || dst_b_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset: valid=%b res=%h flags=%b dst=%b, expected all zero",
                     valid_o, res_o, flags_o, dst_b_o);
        end
        issue("R3 imm +4 left",          0, 0, 0, 16'h0004, 40'h00_1234_5678, 40'h0);
        issue("R3 imm -4 right arith",   0, 1, 0, 16'h00FC, 40'h90_0000_0000, 40'h0);
        issue("R3 imm upper byte ignored", 0, 0, 0, 16'hAB04, 40'h00_0000_00F1, 40'h0);
        issue("R4 reg +3 right",         0, 0, 1, 16'h0003, 40'h80_0000_0000, 40'h0);
        issue("R4 reg 0 unchanged",      1, 1, 1, 16'h0000, 40'h0, 40'hC3_5A5A_0001);
        issue("R4 reg -8 left",          0, 1, 1, 16'hFFF8, 40'h00_00AB_CDEF, 40'h0);
        issue("R2 arith right 8",        0, 1, 1, 16'h0008, 40'h80_0000_0001, 40'h0);
        issue("R1 logic right 8",        0, 0, 1, 16'h0008, 40'h80_0000_0001, 40'h0);
        issue("R2 arith left fills zero", 0, 1, 0, 16'h0001, 40'hFF_FFFF_FFFF, 40'h0);
        idle();
        issue("R7 imm 39 left boundary", 0, 0, 0, 16'h0027, 40'h00_0000_0001, 40'h0);
        issue("R7 imm 40 left zero",     0, 0, 0, 16'h0028, 40'hFF_FFFF_FFFF, 40'h0);
        issue("R7 reg 100 arith right sign", 0, 1, 1, 16'h0064, 40'h80_0000_0000, 40'h0);
        issue("R7 reg 100 logic right zero", 0, 0, 1, 16'h0064, 40'h80_0000_0000, 40'h0);
        issue("R7 imm -128 arith positive", 1, 1, 0, 16'h0080, 40'h0, 40'h7F_FFFF_FFFF);
        issue("R7 reg -32768 left zero", 1, 0, 1, 16'h8000, 40'h0, 40'h00_0000_0001);
        issue("R7 reg 39 arith right",   1, 1, 1, 16'h0027, 40'h0, 40'h80_0000_0000);
        idle();
        issue("R6 select B",             1, 0, 0, 16'h0001, 40'h00_0000_0001, 40'h00_0000_0100);
        issue("R6 select A",             0, 0, 0, 16'h0001, 40'h00_0000_0001, 40'h00_0000_0100);
        issue("R8 zero result",          0, 0, 1, 16'h0001, 40'h00_0000_0001, 40'h0);
        issue("R8 negative result",      0, 0, 0, 16'h0001, 40'h40_0000_0000, 40'h0);
        issue("R5 flags on arith right", 1, 1, 0, 16'h00FF, 40'h0, 40'hF0_0000_0000);
        idle();
        repeat (3) @(negedge clk);
        drv_done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!(drv_done && exp_q.size() == 0) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog: run did not finish, expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule